// File: doc/BRIEF.md
# Sequential Signed/Unsigned Integer Divider

This block divides a 32-bit or a 16-bit dividend by a 16-bit divisor. It returns a 16-bit quotient and a 16-bit remainder on separate ports. One control bit selects two's-complement or unsigned operands. A second control bit selects the long form, where the dividend is the concatenation `{dvd_hi, dvd_lo}`, or the short form, where only `dvd_lo` is used and is widened to 32 bits.

The core divides operand magnitudes with a restoring shift-subtract loop. The loop settles one quotient bit per clock, so the cycle count depends only on the divisor width and both sizes take the same time. Signs are fixed up after the loop. Two status flags are returned with each result: one for a zero divisor and one for a quotient that does not fit the selected 16-bit range.

A caller raises `start` for one cycle while `busy` is low. When `done` pulses, the caller reads the result. The result stays on the outputs until the next result is produced.

Top module: `seqdiv_top`

## Requirements
- R1: After reset, `busy`, `done`, `div_zero`, `ovf`, `quot` and `rem` are all zero.
- R2: In unsigned mode with a non-zero divisor and no overflow, `quot` equals the 32-bit dividend divided by the divisor, rounded down, and `rem` equals the dividend modulo the divisor.
- R3: In signed mode with no overflow, the quotient is truncated toward zero. It is negative when the operand signs differ. The remainder carries the sign of the dividend.
- R4: With `long_mode` = 0, `dvd_hi` has no effect. The dividend is `dvd_lo` sign-extended in signed mode and zero-extended in unsigned mode.
- R5: `done` is high for exactly one cycle, 17 rising edges after the edge that accepted `start` (DW+1 with DW = 16). This holds for both the long and the short form.
- R6: `busy` is high from the accepting edge until the edge that raises `done`. It is low while `done` is high.
- R7: A `start` raised while `busy` is high is ignored. No extra result appears, and the pending result is that of the accepted operands.
- R8: A zero divisor sets `div_zero` = 1 and `ovf` = 0 with the result, still after the fixed latency.
- R9: `ovf` = 1 when the divisor is non-zero and the true quotient lies outside 0..65535 in unsigned mode, or outside -32768..32767 in signed mode.
- R10: `quot`, `rem`, `div_zero` and `ovf` change only on the edge that raises `done`, and hold otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a divide; accepted only when `busy` is low |
| signed_op | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| long_mode | input | 1 | 1 = 32-bit dividend `{dvd_hi,dvd_lo}`, 0 = 16-bit dividend `dvd_lo` |
| dvd_hi | input | 16 | Upper word of the dividend |
| dvd_lo | input | 16 | Lower word of the dividend |
| dvs | input | 16 | Divisor |
| busy | output | 1 | Divide in progress |
| done | output | 1 | One-cycle pulse: results are valid |
| quot | output | 16 | Quotient |
| rem | output | 16 | Remainder |
| div_zero | output | 1 | Divisor was zero |
| ovf | output | 1 | Quotient out of 16-bit range |

## Verification
Every accepted request is stamped with its accepting edge. The scoreboard then expects `done` on exactly edge +17, and `busy` on every edge from the accepting one up to that edge. At each falling edge, the monitor compares `done` and `busy` against the stamp at the head of the queue. On the `done` cycle it compares the flags and, when they allow it, the quotient and remainder with values computed by 64-bit integer division. Between results, it checks that the outputs are unchanged from the last `done`. Requests raised while busy never enter the queue, so any stray or late pulse shows up as a timing mismatch.

// File: rtl/seqdiv_pkg.sv
package seqdiv_pkg;
   // Magnitude and sign information produced by operand conditioning
   typedef struct packed {
      logic neg_n;    // dividend negative (signed mode only)
      logic neg_d;    // divisor negative (signed mode only)
      logic d_zero;   // divisor is zero
      logic hi_ovf;   // upper magnitude word >= divisor magnitude
   } seqdiv_flags_t;
endpackage

// File: rtl/seqdiv_prep.sv
module seqdiv_prep #(
   parameter int DW = 16
) (
   input  logic               signed_op,
   input  logic               long_mode,
   input  logic [DW-1:0]      dvd_hi,
   input  logic [DW-1:0]      dvd_lo,
   input  logic [DW-1:0]      dvs,
   output logic [2*DW-1:0]    mag_n,
   output logic [DW-1:0]      mag_d,
   output seqdiv_pkg::seqdiv_flags_t flags
);
   localparam int NW = 2 * DW;

   logic [NW-1:0] ext_n;
   logic          sfill;

   generate
      if (DW < 2) begin : g_bad_width
         $error("seqdiv_prep: DW must be at least 2");
      end
   endgenerate

   always_comb begin
      sfill = signed_op & dvd_lo[DW-1];
      if (long_mode) ext_n = {dvd_hi, dvd_lo};
      else           ext_n = {{DW{sfill}}, dvd_lo};
      flags.neg_n  = signed_op & ext_n[NW-1];
      flags.neg_d  = signed_op & dvs[DW-1];
      mag_n        = flags.neg_n ? (~ext_n + 1'b1) : ext_n;
      mag_d        = flags.neg_d ? (~dvs + 1'b1) : dvs;
      flags.d_zero = (dvs == '0);
      flags.hi_ovf = (mag_n[NW-1:DW] >= mag_d);
   end
endmodule

// File: rtl/seqdiv_iter.sv
module seqdiv_iter #(
   parameter int DW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [2*DW-1:0] mag_n,
   input  logic [DW-1:0]   mag_d,
   output logic            active,
   output logic            fin,
   output logic [DW-1:0]   q_mag,
   output logic [DW-1:0]   r_mag
);
   localparam int CW = $clog2(DW + 1);

   logic [CW-1:0] cnt;
   logic [DW-1:0] dreg;
   logic [DW-1:0] rreg;
   logic [DW-1:0] qreg;
   logic [DW:0]   trial;
   logic [DW:0]   diff;
   logic          fits;

   generate
      if (CW < 1) begin : g_bad_cnt
         $error("seqdiv_iter: counter width must be positive");
      end
   endgenerate

   // One restoring step: shift the next dividend bit in, subtract when it fits
   always_comb begin
      trial = {rreg, qreg[DW-1]};
      diff  = trial - {1'b0, dreg};
      fits  = (trial >= {1'b0, dreg});
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         dreg   <= '0;
         rreg   <= '0;
         qreg   <= '0;
         active <= 1'b0;
         fin    <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (load) begin
            rreg   <= mag_n[2*DW-1:DW];
            qreg   <= mag_n[DW-1:0];
            dreg   <= mag_d;
            cnt    <= CW'(DW);
            active <= 1'b1;
         end else if (active) begin
            rreg <= fits ? diff[DW-1:0] : trial[DW-1:0];
            qreg <= {qreg[DW-2:0], fits};
            cnt  <= cnt - 1'b1;
            if (cnt == CW'(1)) begin
               active <= 1'b0;
               fin    <= 1'b1;
            end
         end
      end
   end

   assign q_mag = qreg;
   assign r_mag = rreg;

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DW)); // R5
   AST_FIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> !fin); // R5
   AST_FIN_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fin) |-> $past(active)); // R5
endmodule

// File: rtl/seqdiv_post.sv
module seqdiv_post #(
   parameter int DW = 16
) (
   input  logic                      signed_op,
   input  seqdiv_pkg::seqdiv_flags_t flags,
   input  logic [DW-1:0]             q_mag,
   input  logic [DW-1:0]             r_mag,
   output logic [DW-1:0]             quot,
   output logic [DW-1:0]             rem,
   output logic                      div_zero,
   output logic                      ovf
);
   logic neg_q;
   logic range_bad;

   always_comb begin
      neg_q = flags.neg_n ^ flags.neg_d;
      quot  = neg_q ? (~q_mag + 1'b1) : q_mag;
      rem   = flags.neg_n ? (~r_mag + 1'b1) : r_mag;
      if (!signed_op)  range_bad = 1'b0;
      else if (neg_q)  range_bad = q_mag[DW-1] & (|q_mag[DW-2:0]);
      else             range_bad = q_mag[DW-1];
      div_zero = flags.d_zero;
      ovf      = !flags.d_zero & (flags.hi_ovf | range_bad);
   end
endmodule

// File: rtl/seqdiv_top.sv
module seqdiv_top #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          signed_op,
   input  logic          long_mode,
   input  logic [DW-1:0] dvd_hi,
   input  logic [DW-1:0] dvd_lo,
   input  logic [DW-1:0] dvs,
   output logic          busy,
   output logic          done,
   output logic [DW-1:0] quot,
   output logic [DW-1:0] rem,
   output logic          div_zero,
   output logic          ovf
);
   import seqdiv_pkg::*;

   logic [2*DW-1:0] mag_n;
   logic [DW-1:0]   mag_d;
   seqdiv_flags_t   flags_in;
   seqdiv_flags_t   flags_l;
   logic            sgn_l;
   logic [DW-1:0]   dvs_l;
   logic            accept;
   logic            active;
   logic            fin;
   logic [DW-1:0]   q_mag;
   logic [DW-1:0]   r_mag;
   logic [DW-1:0]   quot_c;
   logic [DW-1:0]   rem_c;
   logic            dz_c;
   logic            ovf_c;

   assign busy   = active | fin;
   assign accept = start & !busy;

   seqdiv_prep #(.DW(DW)) u_prep (
      .signed_op (signed_op),
      .long_mode (long_mode),
      .dvd_hi    (dvd_hi),
      .dvd_lo    (dvd_lo),
      .dvs       (dvs),
      .mag_n     (mag_n),
      .mag_d     (mag_d),
      .flags     (flags_in)
   );

   seqdiv_iter #(.DW(DW)) u_iter (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (accept),
      .mag_n  (mag_n),
      .mag_d  (mag_d),
      .active (active),
      .fin    (fin),
      .q_mag  (q_mag),
      .r_mag  (r_mag)
   );

   seqdiv_post #(.DW(DW)) u_post (
      .signed_op (sgn_l),
      .flags     (flags_l),
      .q_mag     (q_mag),
      .r_mag     (r_mag),
      .quot      (quot_c),
      .rem       (rem_c),
      .div_zero  (dz_c),
      .ovf       (ovf_c)
   );

   // Operand context captured at acceptance
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_l <= '0;
         sgn_l   <= 1'b0;
         dvs_l   <= '0;
      end else if (accept) begin
         flags_l <= flags_in;
         sgn_l   <= signed_op;
         dvs_l   <= dvs;
      end
   end

   // Result registers, loaded once per operation
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done     <= 1'b0;
         quot     <= '0;
         rem      <= '0;
         div_zero <= 1'b0;
         ovf      <= 1'b0;
      end else begin
         done <= fin;
         if (fin) begin
            quot     <= quot_c;
            rem      <= rem_c;
            div_zero <= dz_c;
            ovf      <= ovf_c;
         end
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R5
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R6
   AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done); // R6
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(dvs_l) && $stable(sgn_l)); // R7
   AST_DZ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (div_zero == (dvs_l == '0))); // R8
   AST_DZ_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
      (done && div_zero) |-> !ovf); // R8
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !ovf && !div_zero && !sgn_l) |-> (rem < dvs_l)); // R2
   AST_HOLD_QUOT: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(quot) |-> done); // R10
   AST_HOLD_REM: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rem) |-> done); // R10
endmodule

// File: tb/seqdiv_top_bench.sv
`timescale 1ns/1ps
module seqdiv_top_bench;
   localparam int DW  = 16;
   localparam int LAT = DW + 1;

   typedef struct {
      int          due;
      bit          chk_qr;
      logic [15:0] q;
      logic [15:0] r;
      bit          dz;
      bit          ov;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        signed_op = 1'b0;
   logic        long_mode = 1'b0;
   logic [15:0] dvd_hi = '0;
   logic [15:0] dvd_lo = '0;
   logic [15:0] dvs = '0;
   logic        busy, done, div_zero, ovf;
   logic [15:0] quot, rem;

   int   n_checks = 0;
   int   n_fail = 0;
   int   pcnt = 0;
   bit   mon_on = 1'b0;
   bit   held_v = 1'b0;
   logic [15:0] held_q, held_r;
   logic        held_dz, held_ov;
   exp_t sb[$];

   always #2.5 clk = ~clk;

   always @(posedge clk) pcnt <= pcnt + 1;

   seqdiv_top #(.DW(DW)) u_seqdiv_top (
      .clk(clk), .rst_n(rst_n), .start(start), .signed_op(signed_op),
      .long_mode(long_mode), .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .dvs(dvs),
      .busy(busy), .done(done), .quot(quot), .rem(rem),
      .div_zero(div_zero), .ovf(ovf)
   );

   task automatic check(input bit ok, input string what, input longint act, input longint expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
      end
   endtask

   function automatic exp_t model(input bit sgn, input bit lng, input logic [15:0] hi,
                                  input logic [15:0] lo, input logic [15:0] dv, input string tag);
      exp_t e;
      longint n, d, q, r;
      if (lng) n = sgn ? longint'($signed({hi, lo})) : longint'({hi, lo});
      else     n = sgn ? longint'($signed(lo)) : longint'(lo);
      d = sgn ? longint'($signed(dv)) : longint'(dv);
      e.tag = tag;
      e.due = 0;
      if (d == 0) begin
         e.dz = 1; e.ov = 0; e.chk_qr = 0; e.q = '0; e.r = '0;
      end else begin
         q = n / d;
         r = n % d;
         e.dz = 0;
         e.ov = sgn ? (q > 32767 || q < -32768) : (q > 65535);
         e.chk_qr = !e.ov;
         e.q = 16'(q);
         e.r = 16'(r);
      end
      return e;
   endfunction

   // Driver: issue one operation and push its expected result
   task automatic run_op(input bit sgn, input bit lng, input logic [15:0] hi,
                         input logic [15:0] lo, input logic [15:0] dv, input string tag);
      exp_t e;
      @(negedge clk);
      while (busy) @(negedge clk);
      signed_op = sgn; long_mode = lng; dvd_hi = hi; dvd_lo = lo; dvs = dv;
      start = 1'b1;
      e = model(sgn, lng, hi, lo, dv, tag);
      @(posedge clk);
      #1;
      e.due = pcnt + LAT;
      sb.push_back(e);
      start = 1'b0;
      dvd_hi = 16'($urandom); dvd_lo = 16'($urandom); dvs = 16'($urandom);
   endtask

   // Raise start during a busy period with unrelated operands (R7)
   task automatic poke_busy();
      @(negedge clk);
      if (busy) begin
         signed_op = ~signed_op; dvd_lo = 16'h1234; dvs = 16'h0003;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
   endtask

   // Monitor / scoreboard
   always @(negedge clk) begin
      if (mon_on) begin
         bit exp_done, exp_busy;
         exp_done = (sb.size() > 0) && (pcnt == sb[0].due);
         exp_busy = (sb.size() > 0) && (pcnt < sb[0].due);
         check(done == exp_done, "R5 done timing", done, exp_done);
         check(busy == exp_busy, "R6 busy window", busy, exp_busy);
         if (done && exp_done) begin
            exp_t e;
            e = sb.pop_front();
            check(div_zero == e.dz, {e.tag, " R8 div_zero"}, div_zero, e.dz);
            check(ovf == e.ov, {e.tag, " R9 ovf"}, ovf, e.ov);
            if (e.chk_qr) begin
               check(quot == e.q, {e.tag, " quotient"}, quot, e.q);
               check(rem == e.r, {e.tag, " remainder"}, rem, e.r);
            end
            held_v = 1'b1;
            held_q = quot; held_r = rem; held_dz = div_zero; held_ov = ovf;
         end else if (held_v && !done) begin
            check(quot == held_q && rem == held_r && div_zero == held_dz && ovf == held_ov,
                  "R10 outputs hold", {quot, rem}, {held_q, held_r});
         end
      end
   end

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", pcnt, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      check({busy, done, div_zero, ovf} == 4'b0, "R1 reset flags", {busy, done, div_zero, ovf}, 0);
      check(quot == 16'h0 && rem == 16'h0, "R1 reset data", {quot, rem}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check({busy, done, div_zero, ovf} == 4'b0, "R1 after release", {busy, done, div_zero, ovf}, 0);
      mon_on = 1'b1;

      // R2 unsigned long form
      run_op(0, 1, 16'h0001, 16'h86A0, 16'd7, "R2 u32 100000/7");
      run_op(0, 1, 16'hFFFE, 16'hFFFF, 16'hFFFF, "R2 u32 max quotient");
      run_op(0, 1, 16'h0000, 16'h0005, 16'h0009, "R2 u32 small dividend");
      // R3 signed long form
      run_op(1, 1, 16'hFFFE, 16'h7960, 16'd7, "R3 neg/pos");
      run_op(1, 1, 16'h0001, 16'h86A0, 16'hFFF9, "R3 pos/neg");
      run_op(1, 1, 16'hFFFE, 16'h7960, 16'hFFF9, "R3 neg/neg");
      run_op(1, 1, 16'hFFFF, 16'h8000, 16'h0001, "R3 min quotient fits");
      // R4 short form, high word junk
      run_op(1, 0, 16'h1234, 16'hFFF9, 16'd2, "R4 signed short sext");
      run_op(0, 0, 16'hBEEF, 16'hFFF9, 16'd2, "R4 unsigned short zext");
      run_op(0, 0, 16'hFFFF, 16'hFFFF, 16'h0001, "R4 unsigned short max");
      // R8 divide by zero
      run_op(0, 1, 16'h0012, 16'h3456, 16'h0000, "R8 zero u32");
      run_op(1, 0, 16'h0000, 16'h8000, 16'h0000, "R8 zero s16");
      // R9 overflow cases
      run_op(0, 1, 16'h0001, 16'h0000, 16'h0001, "R9 u32 hi eq div");
      run_op(0, 1, 16'hFFFF, 16'h0000, 16'hFFFF, "R9 u32 hi eq max");
      run_op(1, 1, 16'h8000, 16'h0000, 16'hFFFF, "R9 smin/-1");
      run_op(1, 0, 16'h0000, 16'h8000, 16'hFFFF, "R9 s16 -32768/-1");
      run_op(1, 1, 16'h0000, 16'h8000, 16'h0001, "R9 s32 +32768");
      // R7 start while busy
      fork
         run_op(0, 1, 16'h0000, 16'h0064, 16'd10, "R7 kept op");
         begin repeat (3) poke_busy(); end
      join
      run_op(1, 0, 16'h0000, 16'hFF9C, 16'd10, "R7 next op");
      // back-to-back random mix
      for (int i = 0; i < 150; i++) begin
         bit sg, lg;
         logic [15:0] h, l, d;
         sg = 1'($urandom); lg = 1'($urandom);
         l = 16'($urandom); d = 16'($urandom);
         h = (i % 3 == 0) ? 16'($urandom) : 16'($urandom % 32'h100);
         if (i % 4 == 0) d = d | 16'h7000;
         run_op(sg, lg, h, l, d, lg ? (sg ? "R3 rand" : "R2 rand") : "R4 rand");
      end
      while (sb.size() > 0) @(negedge clk);
      repeat (5) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule